// File: doc/BRIEF.md
# Video Status Register with Sticky Flags

This block forms the 10-bit status word of a video display processor. A host CPU reads that word over a 16-bit data bus. Most bits are live levels from the rest of the chip: write-FIFO occupancy, the blanking phases, the interlace field, DMA activity and a board-level region strap. Three bits are sticky. These are the vertical interrupt flag, sprite overflow and sprite collision. Each one is set by a single-cycle event strobe and stays set until the host reads the status register.

A status read is signalled by `stat_rd`. During that cycle the word on `stat_word` shows the flags as they stand. The clock edge that ends the read clears every sticky flag, except a flag whose event arrives in that same cycle. Such a flag stays set for the next read. The block does not drive the top six bits of the bus word. Those bits repeat the upper bits of the last value the host latched from the bus, which `bus_rd` and `bus_word` report.

Top module: `vid_status_reg`

## Requirements
- R1: Bit 9 of `stat_word` is 1 exactly when `fifo_level` is 0.
- R2: Bit 8 of `stat_word` is 1 exactly when `fifo_level` equals the FIFO depth (4 by default). Levels 1 to 3 give 0 in both bit 9 and bit 8.
- R3: A pulse on `spr_ovf_evt` sets bit 6. Bit 6 stays 1 across cycles without a read, reads back as 1 during the status read, and is 0 after that read.
- R4: A pulse on `spr_col_evt` sets bit 5, with the same hold and clear-on-read behaviour as R3.
- R5: A pulse on `vint_evt` sets bit 7 and raises `vint_irq` in the next cycle. Both stay up until a status read and drop after it.
- R6: If a sticky event strobe is high in the same cycle as `stat_rd`, that read returns the flag's old value and the flag is 1 after the read. Flags without an event in that cycle are cleared.
- R7: Bit 4 equals `odd_field` while `interlace_en` is 1, and is 0 while `interlace_en` is 0.
- R8: Bit 3 follows `vblank` and bit 2 follows `hblank` in the same cycle, with no latching.
- R9: Bit 1 follows `dma_busy` and bit 0 follows `region_pal` in the same cycle.
- R10: Bits 15:10 of `stat_word` equal bits 15:10 of `bus_word` at the most recent `bus_rd`. A status read does not change them.
- R11: After reset all sticky flags are 0, `vint_irq` is 0 and bits 15:10 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 3 | Number of pending writes in the host write FIFO |
| vint_evt | input | 1 | Single-cycle strobe: vertical interrupt raised |
| spr_ovf_evt | input | 1 | Single-cycle strobe: sprite overflow detected |
| spr_col_evt | input | 1 | Single-cycle strobe: sprite pixel collision detected |
| interlace_en | input | 1 | Interlace mode active |
| odd_field | input | 1 | Odd field being produced |
| vblank | input | 1 | Vertical blank level |
| hblank | input | 1 | Horizontal blank level |
| dma_busy | input | 1 | DMA transfer running |
| region_pal | input | 1 | Region strap, 1 for 50 Hz systems |
| bus_rd | input | 1 | Host latched a word from the data bus this cycle |
| bus_word | input | 16 | Word the host latched when `bus_rd` is high |
| stat_rd | input | 1 | Host status read in this cycle |
| stat_word | output | 16 | Status word as seen on the bus |
| vint_irq | output | 1 | Vertical interrupt request, equal to the sticky flag |

## Verification
The properties assume that the FIFO level never goes above the configured depth. They also assume that each event input is a strobe, not a level that the block must edge-detect. The stimulus holds every event high for exactly one cycle and only sets `fifo_level` between 0 and 4. The bench never raises `bus_rd` and `stat_rd` together, because the upper-bit property depends on that. A status read and an event strobe do share a cycle deliberately in the R6 check.

// File: rtl/vid_status_pkg.sv
package vid_status_pkg;

    localparam int STAT_W = 10;
    localparam int BUS_W  = 16;
    localparam int UP_W   = BUS_W - STAT_W;

    // sticky flag slots
    localparam int STK_VINT = 0;
    localparam int STK_OVF  = 1;
    localparam int STK_COL  = 2;
    localparam int STK_N    = 3;

    // field order is the bus bit order, MSB first (bit 9 .. bit 0)
    typedef struct packed {
        logic q_empty;
        logic q_full;
        logic vint;
        logic spr_ovf;
        logic spr_col;
        logic odd;
        logic vblank;
        logic hblank;
        logic dma;
        logic pal;
    } stat_t;

    function automatic logic [BUS_W-1:0] join_word(logic [UP_W-1:0] upper, stat_t s);
        return {upper, s};
    endfunction

endpackage

// File: rtl/vsr_fifo_flags.sv
module vsr_fifo_flags #(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    always_comb begin
        empty = (level == '0);
        full  = (level == TOP);
    end
endmodule

// File: rtl/vsr_sticky.sv
module vsr_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[i] <= 1'b0;
            else
                flag[i] <= (flag[i] & ~clr) | evt[i];
        end

        // R3 / R4 / R5: a set flag holds while nothing clears it
        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !clr) |=> flag[i]);

        // R3 / R4 / R5: a read with no new event leaves the flag clear
        p_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !flag[i]);

        // R6: an event always lands, even under a clearing read
        p_survive_r6: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flag[i]);
    end
endmodule

// File: rtl/vsr_bus_hold.sv
module vsr_bus_hold #(
    parameter int UP_W  = 6,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [BUS_W-1:0] word,
    input  logic             own_rd,
    output logic [UP_W-1:0]  upper
);
    always_ff @(posedge clk) begin
        if (rst)
            upper <= '0;
        else if (cap)
            upper <= word[BUS_W-1 -: UP_W];
    end

    // R10: a status read alone leaves the floating bits untouched
    p_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (own_rd && !cap) |=> $stable(upper));
endmodule

// File: rtl/vid_status_reg.sv
module vid_status_reg
    import vid_status_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             vint_evt,
    input  logic             spr_ovf_evt,
    input  logic             spr_col_evt,
    input  logic             interlace_en,
    input  logic             odd_field,
    input  logic             vblank,
    input  logic             hblank,
    input  logic             dma_busy,
    input  logic             region_pal,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_word,
    input  logic             stat_rd,
    output logic [BUS_W-1:0] stat_word,
    output logic             vint_irq
);
    logic             q_empty, q_full;
    logic [STK_N-1:0] evt_v, flag_v;
    logic [UP_W-1:0]  hold_up;
    stat_t            st;

    vsr_fifo_flags #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .level (fifo_level),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        evt_v           = '0;
        evt_v[STK_VINT] = vint_evt;
        evt_v[STK_OVF]  = spr_ovf_evt;
        evt_v[STK_COL]  = spr_col_evt;
    end

    vsr_sticky #(.N(STK_N)) u_sticky (
        .clk  (clk),
        .rst  (rst),
        .clr  (stat_rd),
        .evt  (evt_v),
        .flag (flag_v)
    );

    vsr_bus_hold #(.UP_W(UP_W), .BUS_W(BUS_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cap    (bus_rd),
        .word   (bus_word),
        .own_rd (stat_rd),
        .upper  (hold_up)
    );

    always_comb begin
        st.q_empty = q_empty;
        st.q_full  = q_full;
        st.vint    = flag_v[STK_VINT];
        st.spr_ovf = flag_v[STK_OVF];
        st.spr_col = flag_v[STK_COL];
        st.odd     = interlace_en & odd_field;
        st.vblank  = vblank;
        st.hblank  = hblank;
        st.dma     = dma_busy;
        st.pal     = region_pal;
        stat_word  = join_word(hold_up, st);
        vint_irq   = flag_v[STK_VINT];
    end

    p_fifo_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |-> (stat_word[9] && !stat_word[8]));

    p_fifo_full_r2: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LVL_W'(FIFO_DEPTH)) |-> (stat_word[8] && !stat_word[9]));

    p_vint_raise_r5: assert property (@(posedge clk) disable iff (rst)
        vint_evt |=> (vint_irq && stat_word[7]));

    p_odd_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !interlace_en |-> !stat_word[4]);

    p_live_blank_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_word[3] == vblank) && (stat_word[2] == hblank));
endmodule

// File: tb/vid_status_reg_bench.sv
module vid_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  fifo_level;
    logic        vint_evt, spr_ovf_evt, spr_col_evt;
    logic        interlace_en, odd_field, vblank, hblank, dma_busy, region_pal;
    logic        bus_rd, stat_rd;
    logic [15:0] bus_word, stat_word;
    logic        vint_irq;
    int          total = 0;
    int          bad   = 0;

    always #2 clk = ~clk;

    vid_status_reg u_vid_status_reg (
        .clk(clk), .rst(rst), .fifo_level(fifo_level),
        .vint_evt(vint_evt), .spr_ovf_evt(spr_ovf_evt), .spr_col_evt(spr_col_evt),
        .interlace_en(interlace_en), .odd_field(odd_field),
        .vblank(vblank), .hblank(hblank), .dma_busy(dma_busy), .region_pal(region_pal),
        .bus_rd(bus_rd), .bus_word(bus_word), .stat_rd(stat_rd),
        .stat_word(stat_word), .vint_irq(vint_irq)
    );

    // {level[2:0], ilace, odd, vb, hb, dma, pal, expected low 10 bits}
    localparam logic [18:0] VEC [6] = '{
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h200},
        {3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'h119},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h006},
        {3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h00F},
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h010},
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h21C}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: vint_evt = 1'b1;
            1: spr_ovf_evt = 1'b1;
            default: spr_col_evt = 1'b1;
        endcase
        @(negedge clk);
        vint_evt = 1'b0; spr_ovf_evt = 1'b0; spr_col_evt = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; fifo_level = 3'd0;
        vint_evt = 0; spr_ovf_evt = 0; spr_col_evt = 0;
        interlace_en = 0; odd_field = 0; vblank = 0; hblank = 0;
        dma_busy = 0; region_pal = 0; bus_rd = 0; bus_word = '0; stat_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 word", stat_word, 16'h0200);
        chk("R11 irq", {15'd0, vint_irq}, 16'd0);

        // live-level table: R1 R2 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {fifo_level, interlace_en, odd_field, vblank, hblank, dma_busy, region_pal} = VEC[i][18:10];
            #1;
            chk("R1/R2/R7/R8/R9 table", {6'd0, stat_word[9:0]}, {6'd0, VEC[i][9:0]});
        end
        @(negedge clk);
        {fifo_level, interlace_en, odd_field, vblank, hblank, dma_busy, region_pal} = '0;

        // R3 overflow sticky
        pulse_evt(1);
        repeat (3) @(negedge clk);
        #1;
        chk("R3 held", {15'd0, stat_word[6]}, 16'd1);
        @(negedge clk); stat_rd = 1'b1; #1;
        chk("R3 read value", {15'd0, stat_word[6]}, 16'd1);
        @(negedge clk); stat_rd = 1'b0; #1;
        chk("R3 cleared", {15'd0, stat_word[6]}, 16'd0);

        // R4 collision sticky
        pulse_evt(2);
        chk("R4 set", {15'd0, stat_word[5]}, 16'd1);
        @(negedge clk); stat_rd = 1'b1; #1;
        chk("R4 read value", {15'd0, stat_word[5]}, 16'd1);
        @(negedge clk); stat_rd = 1'b0; #1;
        chk("R4 cleared", {15'd0, stat_word[5]}, 16'd0);

        // R5 vertical interrupt
        pulse_evt(0);
        chk("R5 irq up", {14'd0, vint_irq, stat_word[7]}, 16'd3);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; #1;
        chk("R5 irq down", {14'd0, vint_irq, stat_word[7]}, 16'd0);

        // R6 event during read: ovf already set, new ovf and col arrive with read
        pulse_evt(1);
        @(negedge clk); stat_rd = 1'b1; spr_ovf_evt = 1'b1; spr_col_evt = 1'b1; #1;
        chk("R6 read shows old", {14'd0, stat_word[6:5]}, 16'b10);
        @(negedge clk); stat_rd = 1'b0; spr_ovf_evt = 1'b0; spr_col_evt = 1'b0; #1;
        chk("R6 survived", {14'd0, stat_word[6:5]}, 16'b11);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; #1;
        chk("R6 later read clears", {14'd0, stat_word[6:5]}, 16'b00);

        // R10 floating upper bits
        @(negedge clk); bus_rd = 1'b1; bus_word = 16'hA5C3;
        @(negedge clk); bus_rd = 1'b0; bus_word = 16'h0000; #1;
        chk("R10 captured", {10'd0, stat_word[15:10]}, 16'h0029);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; #1;
        chk("R10 kept after status read", {10'd0, stat_word[15:10]}, 16'h0029);
        @(negedge clk); bus_rd = 1'b1; bus_word = 16'h5800;
        @(negedge clk); bus_rd = 1'b0; #1;
        chk("R10 recaptured", {10'd0, stat_word[15:10]}, 16'h0016);

        // R11 reset clears sticky state and upper bits
        pulse_evt(0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R11 after reset", stat_word, 16'h0200);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule